// File: doc/BRIEF.md
# Strobe-Acknowledge Register Slave Port

This block connects an external processor to a bank of internal 16-bit registers over an asynchronous bus. The bus has separate address and data lines. The processor drives a word address, an active-low chip select, a direction line (high means read, low means write) and write data. It then pulls an active-low data strobe to start the data phase.

The block moves every bus input into its own clock domain through a two-flop synchroniser. It turns each falling edge of the strobe into exactly one register access. The register array answers after a fixed number of clock cycles, set by a parameter. On a read, the block drives the register word onto the data lines and then pulls the acknowledge low one clock later. On a write, it pulls the acknowledge low once the array has taken the word.

When the processor releases the strobe, the block stops driving the data lines and drives the acknowledge high. It lets go of the acknowledge line (high impedance) only when chip select goes inactive. Chip select may stay low across several cycles; each new strobe edge starts a new cycle. The three-state pads are modelled as a value output plus an output-enable output.

Top module: `strobe_ack_slave`

## Requirements
- R1: After synchronous reset, both output enables (`bus_rdata_oe`, `bus_ack_oe`) are 0, so the data lines and the acknowledge line are both in high impedance.
- R2: A write (`bus_rnw`=0) of a word to an address, followed by a read (`bus_rnw`=1) of that address, returns the same 16-bit word on `bus_rdata`.
- R3: On a read, `bus_rdata_oe` is 1 and `bus_rdata` holds the register word for at least one clock before `bus_ack_n` goes to 0 with `bus_ack_oe`=1.
- R4: The acknowledge goes low no sooner than LATENCY+2 clock cycles after the strobe falls, and within LATENCY+8 cycles.
- R5: When the strobe rises after an acknowledged cycle, `bus_rdata_oe` returns to 0 and `bus_ack_n` returns to 1 while `bus_ack_oe` stays 1, as long as chip select is held low.
- R6: `bus_ack_oe` returns to 0 only after chip select is released, and `bus_ack_n` is 1 when that happens.
- R7: With chip select held low, a second strobe falling edge starts a new, independent cycle.
- R8: A strobe that falls while chip select is high is ignored. Both enables stay 0 and no register is written.
- R9: During a write cycle the block never drives the data lines: `bus_rdata_oe` stays 0.
- R10: A strobe held low for a long time causes exactly one access. The acknowledge stays low and no second acknowledge occurs until the strobe rises and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Word address from the processor |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rnw | input | 1 | Direction: 1 read, 0 write |
| bus_strb_n | input | 1 | Data strobe, active low |
| bus_wdata | input | 16 | Write data driven by the processor |
| bus_rdata | output | 16 | Read data value toward the pads |
| bus_rdata_oe | output | 1 | Drive enable for the data lines |
| bus_ack_n | output | 1 | Acknowledge value, active low |
| bus_ack_oe | output | 1 | Drive enable for the acknowledge line |

## Verification
Suppose the controller state were wrong, for example left in the acknowledge-hold state or holding a stale read flag. The processor would then see it within one synchronised strobe edge. Symptoms would be an acknowledge that does not return high, an enable left on after chip select rises, or the data lines driven during a write. Two other faults show up as an acknowledge arriving in the wrong cycle window or a second acknowledge for one strobe: a wrong latency pipeline, or a broken edge detector. A corrupted address or write path shows up on the next read of that word as a data mismatch.

// File: rtl/sas_pkg.sv
package sas_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETTLE,
    ST_HOLD,
    ST_RELEASE
  } sas_state_e;
endpackage

// File: rtl/sas_sync.sv
module sas_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= '0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/sas_regfile.sv
module sas_regfile #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd0;
  logic              v0;

  // read-first single port, block RAM friendly (no reset on array)
  always_ff @(posedge clk) begin
    if (req && we) mem[addr] <= wdata;
    if (req)       rd0       <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) v0 <= 1'b0;
    else     v0 <= req;
  end

  if (LATENCY <= 1) begin : g_direct
    assign rsp_valid = v0;
    assign rdata     = rd0;
  end else begin : g_pipe
    logic              vp [LATENCY-1];
    logic [DATA_W-1:0] dp [LATENCY-1];

    always_ff @(posedge clk) begin
      if (rst) vp[0] <= 1'b0;
      else     vp[0] <= v0;
      dp[0] <= rd0;
    end

    for (genvar i = 1; i < LATENCY-1; i++) begin : g_lat
      always_ff @(posedge clk) begin
        if (rst) vp[i] <= 1'b0;
        else     vp[i] <= vp[i-1];
        dp[i] <= dp[i-1];
      end
    end

    assign rsp_valid = vp[LATENCY-2];
    assign rdata     = dp[LATENCY-2];
  end
endmodule

// File: rtl/sas_ctrl.sv
module sas_ctrl
  import sas_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              rnw_s,
  input  logic              strb_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [WORD_W-1:0] wdata_s,
  output logic              rf_req,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [WORD_W-1:0] rf_wdata,
  input  logic              rf_valid,
  input  logic [WORD_W-1:0] rf_rdata,
  output logic [WORD_W-1:0] out_data,
  output logic              out_data_oe,
  output logic              out_ack_n,
  output logic              out_ack_oe
);
  sas_state_e state;
  logic       strb_q;
  logic       is_rd;
  logic       start;

  // one access per strobe assertion, only with chip select active
  assign start = strb_s && !strb_q && cs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      strb_q      <= 1'b0;
      is_rd       <= 1'b0;
      rf_req      <= 1'b0;
      rf_we       <= 1'b0;
      rf_addr     <= '0;
      rf_wdata    <= '0;
      out_data    <= '0;
      out_data_oe <= 1'b0;
      out_ack_n   <= 1'b1;
      out_ack_oe  <= 1'b0;
    end else begin
      strb_q <= strb_s;
      rf_req <= 1'b0;
      unique case (state)
        ST_IDLE, ST_RELEASE: begin
          if (start) begin
            rf_req   <= 1'b1;
            rf_we    <= !rnw_s;
            rf_addr  <= addr_s;
            rf_wdata <= wdata_s;
            is_rd    <= rnw_s;
            state    <= ST_WAIT;
          end else if (state == ST_RELEASE && !cs_s) begin
            out_ack_oe <= 1'b0;
            state      <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (rf_valid) begin
            if (is_rd) begin
              out_data    <= rf_rdata;
              out_data_oe <= 1'b1;
            end
            state <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          out_ack_n  <= 1'b0;
          out_ack_oe <= 1'b1;
          state      <= ST_HOLD;
        end
        ST_HOLD: begin
          if (!strb_s || !cs_s) begin
            out_data_oe <= 1'b0;
            out_ack_n   <= 1'b1;
            state       <= ST_RELEASE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/strobe_ack_slave.sv
module strobe_ack_slave
  import sas_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LATENCY    = 3,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_cs_n,
  input  logic              bus_rnw,
  input  logic              bus_strb_n,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_rdata_oe,
  output logic              bus_ack_n,
  output logic              bus_ack_oe
);
  localparam int SW = 3 + ADDR_W + WORD_W;

  logic [SW-1:0]     raw_v, syn_v;
  logic              cs_s, rnw_s, strb_s;
  logic [ADDR_W-1:0] addr_s;
  logic [WORD_W-1:0] wdata_s;
  logic              rf_req, rf_we, rf_valid;
  logic [ADDR_W-1:0] rf_addr;
  logic [WORD_W-1:0] rf_wdata, rf_rdata;

  assign raw_v = {!bus_cs_n, bus_rnw, !bus_strb_n, bus_addr, bus_wdata};

  sas_sync #(.W(SW), .STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw_v),
    .dout(syn_v)
  );

  assign {cs_s, rnw_s, strb_s, addr_s, wdata_s} = syn_v;

  sas_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cs_s       (cs_s),
    .rnw_s      (rnw_s),
    .strb_s     (strb_s),
    .addr_s     (addr_s),
    .wdata_s    (wdata_s),
    .rf_req     (rf_req),
    .rf_we      (rf_we),
    .rf_addr    (rf_addr),
    .rf_wdata   (rf_wdata),
    .rf_valid   (rf_valid),
    .rf_rdata   (rf_rdata),
    .out_data   (bus_rdata),
    .out_data_oe(bus_rdata_oe),
    .out_ack_n  (bus_ack_n),
    .out_ack_oe (bus_ack_oe)
  );

  sas_regfile #(.ADDR_W(ADDR_W), .DATA_W(WORD_W), .LATENCY(LATENCY)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .req      (rf_req),
    .we       (rf_we),
    .addr     (rf_addr),
    .wdata    (rf_wdata),
    .rsp_valid(rf_valid),
    .rdata    (rf_rdata)
  );
endmodule

// File: rtl/sas_checker.sv
module sas_checker #(
  parameter int LATENCY = 3
) (
  input logic        clk,
  input logic        rst,
  input logic        bus_cs_n,
  input logic        bus_strb_n,
  input logic [15:0] bus_rdata,
  input logic        bus_rdata_oe,
  input logic        bus_ack_n,
  input logic        bus_ack_oe
);
  logic       ack_act;
  logic       strb_prev;
  logic [7:0] since_fall;

  assign ack_act = bus_ack_oe && !bus_ack_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_prev  <= 1'b1;
      since_fall <= '0;
    end else begin
      strb_prev <= bus_strb_n;
      if (!bus_strb_n && strb_prev && !bus_cs_n) since_fall <= 8'd1;
      else if (since_fall != 8'hFF)             since_fall <= since_fall + 8'd1;
    end
  end

  assert_reset_hiz_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_rdata_oe && !bus_ack_oe));

  assert_data_before_ack_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(ack_act) && bus_rdata_oe) |-> ($past(bus_rdata_oe) && $stable(bus_rdata)));

  assert_min_latency_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_act) |-> (since_fall >= 8'(LATENCY + 2)));

  assert_data_off_ack_high_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rdata_oe) |-> (bus_ack_n && bus_ack_oe));

  assert_ack_release_high_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ack_oe) |-> ($past(bus_ack_n) && bus_ack_n));
endmodule

bind strobe_ack_slave sas_checker #(.LATENCY(LATENCY)) u_sas_checker (
  .clk         (clk),
  .rst         (rst),
  .bus_cs_n    (bus_cs_n),
  .bus_strb_n  (bus_strb_n),
  .bus_rdata   (bus_rdata),
  .bus_rdata_oe(bus_rdata_oe),
  .bus_ack_n   (bus_ack_n),
  .bus_ack_oe  (bus_ack_oe)
);

// File: tb/strobe_ack_slave_bench.sv
module strobe_ack_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int LAT        = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_cs_n = 1'b1;
  logic              bus_rnw = 1'b1;
  logic              bus_strb_n = 1'b1;
  logic [15:0]       bus_wdata = '0;
  logic [15:0]       bus_rdata;
  logic              bus_rdata_oe, bus_ack_n, bus_ack_oe;

  int total = 0;
  int bad   = 0;

  typedef struct packed {
    logic        rd;
    logic [15:0] data;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_ack_slave #(.ADDR_W(ADDR_W), .LATENCY(LAT)) u_strobe_ack_slave (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
    .bus_rnw(bus_rnw), .bus_strb_n(bus_strb_n), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
    .bus_ack_n(bus_ack_n), .bus_ack_oe(bus_ack_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: one expected item per acknowledge falling edge
  logic ack_prev = 1'b0;
  always @(negedge clk) begin
    logic act;
    act = bus_ack_oe && !bus_ack_n;
    if (!rst && act && !ack_prev) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 extra ack", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(bus_rdata_oe == e.rd, e.rd ? "R3 read drive" : "R9 write no drive",
              int'(bus_rdata_oe), int'(e.rd));
        if (e.rd) check(bus_rdata == e.data, "R2 read data", int'(bus_rdata), int'(e.data));
      end
    end
    ack_prev = act;
  end

  logic [15:0] model [1<<ADDR_W];

  // one bus cycle; hold = extra cycles the strobe stays low after ack
  task automatic cycle(input bit rd, input logic [ADDR_W-1:0] a, input logic [15:0] d,
                       input int hold, input bit drop_cs);
    int n;
    exp_t e;
    @(negedge clk);
    bus_addr = a; bus_rnw = rd; bus_wdata = d; bus_cs_n = 1'b0;
    e.rd = rd;
    e.data = rd ? model[a] : 16'h0;
    if (!rd) model[a] = d;
    exp_q.push_back(e);
    @(negedge clk);
    bus_strb_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!(bus_ack_oe && !bus_ack_n) && n < 40);
    check(n >= LAT + 2 && n <= LAT + 8, "R4 ack latency", n, LAT + 5);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(bus_ack_oe && !bus_ack_n, "R10 ack held while strobe low", int'(bus_ack_n), 0);
    end
    bus_strb_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!bus_ack_n && n < 20);
    check(bus_ack_n && bus_ack_oe && !bus_rdata_oe, "R5 release after strobe",
          {bus_ack_n, bus_ack_oe, bus_rdata_oe}, 3'b110);
    if (drop_cs) begin
      bus_cs_n = 1'b1;
      repeat (5) @(negedge clk);
      check(!bus_ack_oe && bus_ack_n, "R6 ack released on cs", {bus_ack_oe, bus_ack_n}, 2'b01);
    end else begin
      repeat (3) @(negedge clk);
      check(bus_ack_oe && bus_ack_n, "R6 ack kept driven high with cs", {bus_ack_oe, bus_ack_n}, 2'b11);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!bus_rdata_oe && !bus_ack_oe, "R1 reset hi-z", {bus_rdata_oe, bus_ack_oe}, 0);

    // R2 / R9: writes of several patterns, then reads back
    cycle(1'b0, 6'd0,  16'hA5A5, 0, 1'b1);
    cycle(1'b0, 6'd63, 16'hFFFF, 0, 1'b1);
    cycle(1'b0, 6'd17, 16'h0001, 0, 1'b1);
    cycle(1'b1, 6'd0,  16'h0, 0, 1'b1);
    cycle(1'b1, 6'd63, 16'h0, 0, 1'b1);
    cycle(1'b1, 6'd17, 16'h0, 0, 1'b1);

    // R7: back-to-back with chip select held low
    cycle(1'b0, 6'd5, 16'h1234, 0, 1'b0);
    cycle(1'b1, 6'd5, 16'h0,    0, 1'b0);
    cycle(1'b0, 6'd5, 16'hBEEF, 0, 1'b0);
    cycle(1'b1, 6'd5, 16'h0,    0, 1'b1);

    // R10: long strobe gives one access only
    cycle(1'b1, 6'd63, 16'h0, 12, 1'b1);

    // R8: strobe with chip select inactive is ignored
    @(negedge clk);
    bus_cs_n = 1'b1; bus_rnw = 1'b0; bus_addr = 6'd17; bus_wdata = 16'hDEAD;
    @(negedge clk);
    bus_strb_n = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (i == 14)
        check(!bus_rdata_oe && !bus_ack_oe, "R8 ignored strobe hi-z", {bus_rdata_oe, bus_ack_oe}, 0);
    end
    bus_strb_n = 1'b1;
    repeat (4) @(negedge clk);
    cycle(1'b1, 6'd17, 16'h0, 0, 1'b1);   // R8 register unchanged

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R7 every cycle acknowledged", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule